// File: doc/BRIEF.md
# Page-Local Conditional Branch Unit

This block computes the next program counter for a three-byte conditional branch whose condition is named by an arbitrary byte code. It also computes the two high-byte compare helpers, signed and unsigned, that rewrite the upper byte of a 16-bit accumulator. The operands arrive already fetched: the current PC, the accumulator, the condition byte, the displacement byte and one zero-page byte. The block never touches memory.

A taken branch stays inside the current 256-byte page. Only the low byte of the PC is replaced, by the displacement plus two. A branch that is not taken steps three bytes forward with the low byte wrapping inside the page. The signed tests come straight from the accumulator value. No flags register is involved.

All results are registered, so each set of inputs appears on the outputs one clock later.

Top module: `pbr_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` and `acc_o` are 0 and `taken_o` and `err_o` are 0.
- R2: Outputs change only at a rising clock edge. They show the results for the inputs sampled at the previous edge, which is a latency of one cycle.
- R3: With `op_i` = 0 (branch), the condition byte selects the test. 0x3F takes the branch when the accumulator is zero. 0x72 takes it when the accumulator is non-zero. 0x50 takes it when bit 15 is set. 0x53 takes it when bit 15 is clear. 0x4D takes it when the value is non-zero and bit 15 is clear. 0x56 takes it when bit 15 is set or the value is zero.
- R4: A taken branch sets `taken_o`. The high byte of `pc_o` stays as in `pc_i`, and the low byte becomes (`disp_i` + 2) mod 256.
- R5: A branch on a known code that is not taken clears `taken_o`. The low byte of `pc_o` becomes (`pc_i[7:0]` + 3) mod 256 and the high byte is kept.
- R6: A branch whose condition byte is not one of the six codes sets `err_o`, clears `taken_o`, and returns `pc_o` = `pc_i` and `acc_o` = `acc_i`.
- R7: With `op_i` = 1 (signed compare), if bit 15 of the accumulator differs from bit 7 of `mem_i`, the new high byte is `mem_i`+1 when `mem_i[7]` is set and `mem_i`−1 otherwise, both mod 256. If the bits agree, the accumulator is unchanged.
- R8: With `op_i` = 2 (unsigned compare), the same rule as R7 applies with the two cases swapped: `mem_i`−1 when `mem_i[7]` is set and `mem_i`+1 otherwise.
- R9: Both compare operations keep the accumulator low byte and clear `taken_o` and `err_o`. They advance the low byte of the PC by 2 mod 256 and keep its high byte.
- R10: A branch with a known code leaves the accumulator unchanged.
- R11: With `op_i` = 3 (pass), `pc_o` = `pc_i`, `acc_o` = `acc_i`, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 0 branch, 1 signed compare, 2 unsigned compare, 3 pass |
| pc_i | input | 16 | Current program counter |
| acc_i | input | 16 | Current accumulator |
| cond_i | input | 8 | Condition code byte for the branch |
| disp_i | input | 8 | Branch displacement byte |
| mem_i | input | 8 | Zero-page operand for the compares |
| pc_o | output | 16 | Next program counter |
| acc_o | output | 16 | Updated accumulator |
| taken_o | output | 1 | Branch taken |
| err_o | output | 1 | Unknown condition code |

## Verification
The hardest situations to reach from the ports sit at the edges of the signed tests and of the in-page wrap. These include GT and LE on an accumulator of exactly zero, 0x8000 and 0x7FFF. They also include a not-taken branch from a low PC byte of 0xFD to 0xFF, and a displacement of 0xFE or 0xFF. Random draws rarely land on those points, so directed cases place them explicitly. The random mix draws accumulators from a pool of boundary values one time in four, and draws condition bytes from a pool of known codes three times in four. This keeps the error path exercised while the branch tests stay well covered.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

   typedef enum logic [1:0] {
      OP_BRANCH = 2'd0,
      OP_CMP_S  = 2'd1,
      OP_CMP_U  = 2'd2,
      OP_PASS   = 2'd3
   } pbr_op_e;

   localparam logic [7:0] CC_ZERO    = 8'h3F;
   localparam logic [7:0] CC_NONZERO = 8'h72;
   localparam logic [7:0] CC_NEG     = 8'h50;
   localparam logic [7:0] CC_POS     = 8'h4D;
   localparam logic [7:0] CC_NONPOS  = 8'h56;
   localparam logic [7:0] CC_NONNEG  = 8'h53;

endpackage

// File: rtl/pbr_cond_eval.sv
module pbr_cond_eval #(
   parameter int DATA_W = 16,
   parameter int CODE_W = 8
) (
   input  logic [DATA_W-1:0] acc_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              take_o,
   output logic              known_o
);
   import pbr_pkg::*;

   localparam int SIGN_BIT = DATA_W - 1;

   logic is_zero;
   logic is_neg;

   assign is_zero = (acc_i == '0);
   assign is_neg  = acc_i[SIGN_BIT];

   always_comb begin
      take_o  = 1'b0;
      known_o = 1'b1;
      unique case (code_i)
         CODE_W'(CC_ZERO):    take_o = is_zero;
         CODE_W'(CC_NONZERO): take_o = !is_zero;
         CODE_W'(CC_NEG):     take_o = is_neg;
         CODE_W'(CC_NONNEG):  take_o = !is_neg;
         CODE_W'(CC_POS):     take_o = !is_neg && !is_zero;
         CODE_W'(CC_NONPOS):  take_o = is_neg || is_zero;
         default:             known_o = 1'b0;
      endcase
   end

   always_comb begin
      if (!known_o) assert (!take_o); // R6
   end

endmodule

// File: rtl/pbr_hicmp.sv
module pbr_hicmp #(
   parameter int DATA_W     = 16,
   parameter int BYTE_W     = 8,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [DATA_W-1:0] acc_i,
   input  logic [BYTE_W-1:0] mem_i,
   output logic [DATA_W-1:0] acc_o
);
   localparam int HI_LSB = DATA_W - BYTE_W;

   logic              signs_differ;
   logic [BYTE_W-1:0] bump_up;
   logic [BYTE_W-1:0] bump_dn;
   logic [BYTE_W-1:0] new_hi;

   assign signs_differ = acc_i[DATA_W-1] ^ mem_i[BYTE_W-1];
   assign bump_up      = mem_i + BYTE_W'(1);
   assign bump_dn      = mem_i - BYTE_W'(1);

   generate
      if (SIGNED_CMP) begin : g_signed
         assign new_hi = mem_i[BYTE_W-1] ? bump_up : bump_dn;
      end else begin : g_unsigned
         assign new_hi = mem_i[BYTE_W-1] ? bump_dn : bump_up;
      end
   endgenerate

   assign acc_o = signs_differ ? {new_hi, acc_i[HI_LSB-1:0]} : acc_i;

   always_comb begin
      if (!signs_differ) assert (acc_o == acc_i); // R7
   end

endmodule

// File: rtl/pbr_page_add.sv
module pbr_page_add #(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 8
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [PAGE_W-1:0] lo_i,
   input  logic [PAGE_W-1:0] inc_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [PAGE_W-1:0] lo_sum;

   assign lo_sum = lo_i + inc_i;
   assign addr_o = {base_i[ADDR_W-1:PAGE_W], lo_sum};

endmodule

// File: rtl/pbr_unit.sv
module pbr_unit #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [BYTE_W-1:0] cond_i,
   input  logic [BYTE_W-1:0] disp_i,
   input  logic [BYTE_W-1:0] mem_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] acc_o,
   output logic              taken_o,
   output logic              err_o
);
   import pbr_pkg::*;

   localparam int          N_CMP     = 2;
   localparam logic [BYTE_W-1:0] STEP_TAKEN = BYTE_W'(2);
   localparam logic [BYTE_W-1:0] STEP_FALL  = BYTE_W'(3);
   localparam logic [BYTE_W-1:0] STEP_CMP   = BYTE_W'(2);

   initial begin
      assert (ADDR_W > BYTE_W) else $error("ADDR_W must exceed BYTE_W");
      assert (DATA_W == 2 * BYTE_W) else $error("DATA_W must be two bytes");
   end

   pbr_op_e op;
   assign op = pbr_op_e'(op_i);

   logic cond_take;
   logic cond_known;

   pbr_cond_eval #(.DATA_W(DATA_W), .CODE_W(BYTE_W)) u_cond (
      .acc_i  (acc_i),
      .code_i (cond_i),
      .take_o (cond_take),
      .known_o(cond_known)
   );

   logic [DATA_W-1:0] cmp_acc [N_CMP];

   generate
      for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
         pbr_hicmp #(
            .DATA_W    (DATA_W),
            .BYTE_W    (BYTE_W),
            .SIGNED_CMP(g == 0)
         ) u_hicmp (
            .acc_i(acc_i),
            .mem_i(mem_i),
            .acc_o(cmp_acc[g])
         );
      end
   endgenerate

   logic [BYTE_W-1:0] lo_src;
   logic [BYTE_W-1:0] lo_inc;
   logic [ADDR_W-1:0] stepped_pc;

   always_comb begin
      lo_src = pc_i[BYTE_W-1:0];
      lo_inc = STEP_CMP;
      if (op == OP_BRANCH) begin
         lo_src = cond_take ? disp_i : pc_i[BYTE_W-1:0];
         lo_inc = cond_take ? STEP_TAKEN : STEP_FALL;
      end
   end

   pbr_page_add #(.ADDR_W(ADDR_W), .PAGE_W(BYTE_W)) u_page (
      .base_i(pc_i),
      .lo_i  (lo_src),
      .inc_i (lo_inc),
      .addr_o(stepped_pc)
   );

   logic [ADDR_W-1:0] pc_d;
   logic [DATA_W-1:0] acc_d;
   logic              taken_d;
   logic              err_d;

   always_comb begin
      pc_d    = pc_i;
      acc_d   = acc_i;
      taken_d = 1'b0;
      err_d   = 1'b0;
      unique case (op)
         OP_BRANCH: begin
            if (cond_known) begin
               pc_d    = stepped_pc;
               taken_d = cond_take;
            end else begin
               err_d = 1'b1;
            end
         end
         OP_CMP_S: begin
            pc_d  = stepped_pc;
            acc_d = cmp_acc[0];
         end
         OP_CMP_U: begin
            pc_d  = stepped_pc;
            acc_d = cmp_acc[1];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_o    <= '0;
         acc_o   <= '0;
         taken_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         pc_o    <= pc_d;
         acc_o   <= acc_d;
         taken_o <= taken_d;
         err_o   <= err_d;
      end
   end

   logic past_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_q <= 1'b0;
      else        past_q <= 1'b1;
   end

   AST_TAKEN_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n || !past_q)
      taken_o |-> (pc_o[ADDR_W-1:BYTE_W] == $past(pc_i[ADDR_W-1:BYTE_W]) &&
                   pc_o[BYTE_W-1:0] == BYTE_W'($past(disp_i) + STEP_TAKEN))); // R4
   AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !past_q)
      err_o |-> (pc_o == $past(pc_i) && acc_o == $past(acc_i))); // R6
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({taken_o, err_o})); // R6
   AST_CMP_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n || !past_q)
      ($past(op_i) == 2'd1 || $past(op_i) == 2'd2) |->
         (acc_o[BYTE_W-1:0] == $past(acc_i[BYTE_W-1:0]) && !taken_o && !err_o)); // R9
   AST_BRANCH_ACC: assert property (@(posedge clk) disable iff (!rst_n || !past_q)
      ($past(op_i) == 2'd0) |-> (acc_o == $past(acc_i))); // R10
   AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n || !past_q)
      ($past(op_i) == 2'd3) |-> (pc_o == $past(pc_i) && !taken_o && !err_o)); // R11

endmodule

// File: tb/sim_pbr_unit.sv
`timescale 1ns/1ps
module sim_pbr_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  op_i = '0;
   logic [15:0] pc_i = '0;
   logic [15:0] acc_i = '0;
   logic [7:0]  cond_i = '0;
   logic [7:0]  disp_i = '0;
   logic [7:0]  mem_i = '0;
   logic [15:0] pc_o;
   logic [15:0] acc_o;
   logic        taken_o;
   logic        err_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pbr_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .pc_i(pc_i), .acc_i(acc_i),
      .cond_i(cond_i), .disp_i(disp_i), .mem_i(mem_i),
      .pc_o(pc_o), .acc_o(acc_o), .taken_o(taken_o), .err_o(err_o)
   );

   task automatic check(input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic void model(input logic [1:0] op, input logic [15:0] pc, acc,
                                 input logic [7:0] cond, disp, mem,
                                 output logic [15:0] epc, eacc,
                                 output logic et, ee);
      logic known, take, differ;
      logic [7:0] hi;
      epc = pc; eacc = acc; et = 1'b0; ee = 1'b0;
      case (op)
         2'd0: begin
            known = 1'b1; take = 1'b0;
            case (cond)
               8'h3F: take = (acc == 16'h0);
               8'h72: take = (acc != 16'h0);
               8'h50: take = acc[15];
               8'h53: take = !acc[15];
               8'h4D: take = !acc[15] && acc != 16'h0;
               8'h56: take = acc[15] || acc == 16'h0;
               default: known = 1'b0;
            endcase
            if (!known) ee = 1'b1;
            else if (take) begin
               et = 1'b1;
               epc = {pc[15:8], 8'(disp + 8'd2)};
            end else epc = {pc[15:8], 8'(pc[7:0] + 8'd3)};
         end
         2'd1, 2'd2: begin
            epc = {pc[15:8], 8'(pc[7:0] + 8'd2)};
            differ = acc[15] ^ mem[7];
            if (op == 2'd1) hi = mem[7] ? 8'(mem + 8'd1) : 8'(mem - 8'd1);
            else            hi = mem[7] ? 8'(mem - 8'd1) : 8'(mem + 8'd1);
            if (differ) eacc = {hi, acc[7:0]};
         end
         default: ;
      endcase
   endfunction

   function automatic string tag_of(input logic [1:0] op, input logic err);
      if (op == 2'd1) return "R7";
      if (op == 2'd2) return "R8";
      if (op == 2'd3) return "R11";
      if (err) return "R6";
      return "R3";
   endfunction

   task automatic step(input logic [1:0] op, input logic [15:0] pc, acc,
                       input logic [7:0] cond, disp, mem);
      logic [15:0] epc, eacc;
      logic et, ee;
      string t;
      @(negedge clk);
      op_i = op; pc_i = pc; acc_i = acc; cond_i = cond; disp_i = disp; mem_i = mem;
      model(op, pc, acc, cond, disp, mem, epc, eacc, et, ee);
      t = tag_of(op, ee);
      @(posedge clk);
      #1;
      check(t, "pc", pc_o, epc);
      check((op == 2'd1 || op == 2'd2) ? "R9" : (op == 2'd0 && !ee) ? "R10" : t,
            "acc", acc_o, eacc);
      check(t, "taken", {15'd0, taken_o}, {15'd0, et});
      check(t, "err", {15'd0, err_o}, {15'd0, ee});
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] codes [6];
      logic [15:0] edges [6];
      codes = '{8'h3F, 8'h72, 8'h50, 8'h4D, 8'h56, 8'h53};
      edges = '{16'h0000, 16'h8000, 16'h7FFF, 16'hFFFF, 16'h0001, 16'h0080};
      void'($urandom(32'd20240611));

      // R1: reset state
      op_i = 2'd3; pc_i = 16'h1234; acc_i = 16'h5678;
      repeat (3) @(posedge clk);
      #1;
      check("R1", "pc", pc_o, 16'h0);
      check("R1", "acc", acc_o, 16'h0);
      check("R1", "flags", {14'd0, taken_o, err_o}, 16'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: output holds until the next edge
      step(2'd3, 16'hABCD, 16'h1111, 8'h00, 8'h00, 8'h00);
      @(negedge clk);
      pc_i = 16'h0F0F; acc_i = 16'h2222;
      #1;
      check("R2", "pc before edge", pc_o, 16'hABCD);
      @(posedge clk);
      #1;
      check("R2", "pc after edge", pc_o, 16'h0F0F);

      // R3: boundary accumulators for every code
      foreach (codes[c]) begin
         foreach (edges[e]) step(2'd0, 16'h4410, edges[e], codes[c], 8'h40, 8'h00);
      end
      // R4: taken with displacement wrap
      step(2'd0, 16'h12F0, 16'h0000, 8'h3F, 8'hFE, 8'h00);
      step(2'd0, 16'h12F0, 16'h0000, 8'h3F, 8'hFF, 8'h00);
      // R5: not taken with in-page wrap
      for (int lo = 8'hFD; lo <= 8'hFF; lo++)
         step(2'd0, {8'h77, 8'(lo)}, 16'h0005, 8'h3F, 8'h10, 8'h00);
      // R6: unknown codes
      step(2'd0, 16'h3456, 16'h9999, 8'h00, 8'h10, 8'h00);
      step(2'd0, 16'h3456, 16'h0000, 8'hFF, 8'h10, 8'h00);
      // R7, R8: sign differ and agree, wrap of mem +/- 1
      step(2'd1, 16'h20FF, 16'h0034, 8'h00, 8'h00, 8'hFF);
      step(2'd1, 16'h2000, 16'h8034, 8'h00, 8'h00, 8'h00);
      step(2'd1, 16'h2000, 16'h8034, 8'h00, 8'h00, 8'h90);
      step(2'd2, 16'h20FE, 16'h0034, 8'h00, 8'h00, 8'h80);
      step(2'd2, 16'h2000, 16'hFF34, 8'h00, 8'h00, 8'h7F);
      step(2'd2, 16'h2000, 16'h0034, 8'h00, 8'h00, 8'h7F);

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [1:0]  op;
         logic [15:0] acc;
         logic [7:0]  cond;
         op   = 2'($urandom % 4);
         acc  = ($urandom % 4 == 0) ? edges[$urandom % 6] : 16'($urandom);
         cond = ($urandom % 4 != 0) ? codes[$urandom % 6] : 8'($urandom);
         step(op, 16'($urandom), acc, cond, 8'($urandom), 8'($urandom));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule